// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive Controller

This block is the device-side logic of an extended-data-out DRAM that decides whether the data pins are driven or left floating. It watches the four active-low strobes (row strobe, column strobe, write strobe and output-enable strobe). These are asynchronous to the fast system clock, so each passes through a two-flop synchroniser, and all edges are detected on the synchronised copies. A read-data-valid pulse from the array tells the block that the word for the current column access is ready. The block captures that word and decides, every clock, whether to assert the pad drive enable.

The defining behaviour is the EDO hold. When the column strobe rises inside an open row, the pins keep driving the last word. Three things end that hold with a disable that lasts until the next column-strobe fall: output enable held high across the column-strobe rise, an output-enable high pulse of at least `OEP_MIN` clocks while the column strobe is high, and the write strobe going low while the column strobe is high. An early write keeps the pins floating for the whole access. Closing the row, or a row-only cycle, never drives them.

Top module: `edo_dq_drive`

## Requirements
- R1: After reset `dq_oe` is 0 and `dq_out` is all zeros.
- R2: In a read access (row and column strobes low, write strobe high, output enable low), a `rd_valid` pulse captures `rd_data` into `dq_out` and then asserts `dq_oe`.
- R3: After a column-strobe fall, `dq_oe` stays 0 until `rd_valid` has been seen in that access.
- R4: When the column strobe rises with output enable low and the row still open, `dq_oe` stays 1 and `dq_out` keeps the last word.
- R5: If output enable is high when the column strobe rises, `dq_oe` goes to 0 and stays 0 even after output enable returns low. It is released only by the next column-strobe fall and a new `rd_valid`.
- R6: While the column strobe is high inside an open row, an output-enable high pulse of at least `OEP_MIN` clocks disables `dq_oe` until the next column-strobe fall. A shorter pulse only blanks the output while it lasts.
- R7: While the column and row strobes are low and the write strobe is high, output enable high clears `dq_oe` and output enable low sets it again.
- R8: If the write strobe is low at the column-strobe fall (early write), `dq_oe` stays 0 for that whole access, whatever output enable or a later write-strobe level does. `rd_valid` in that access leaves `dq_out` unchanged.
- R9: The write strobe going low while the column strobe is high in an open row disables `dq_oe` until the next column-strobe fall, even after the write strobe returns high.
- R10: The row strobe going high clears `dq_oe`.
- R11: In a row-only cycle (column strobe held high), `dq_oe` stays 0 and `rd_valid` leaves `dq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rd_valid | input | 1 | One-clock pulse: array word for this access is ready |
| rd_data | input | DQ_W | Array read word, valid with `rd_valid` |
| dq_oe | output | 1 | Pad drive enable (1 = drive, 0 = high impedance) |
| dq_out | output | DQ_W | Word held for the pads |

## Verification
Two events can land in the same synchronised clock: a column-strobe rise, and an output-enable or write-strobe level that arms a sticky disable. The bench provokes this by raising output enable while the column strobe is still low and then raising the column strobe. It judges the result by requiring that `dq_oe` stays low after output enable drops again, while `dq_out` still shows the previous word. A second conflict is a column-strobe fall meeting a stale data-valid flag. For this case the bench checks that no drive appears until the new `rd_valid` arrives, and that the sticky disable is released by that same fall.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;
  // Strobes after synchronisation, 1 = asserted (pin low)
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strobe_t;

  localparam int STROBE_N = 4;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edo_drive_ctl.sv
module edo_drive_ctl
  import edo_dq_pkg::*;
#(
  parameter int OEP_MIN = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t s,
  input  logic    rd_valid,
  output logic    load,
  output logic    dq_oe,
  output logic    cas_fall,
  output logic    early_wr,
  output logic    off_sticky
);
  localparam int CNT_W = $clog2(OEP_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OEP_MIN - 1);

  logic             cas_prev;
  logic             cas_rise;
  logic             data_ok;
  logic [CNT_W-1:0] oe_cnt;
  logic             page_idle;
  logic             oe_pulse_on;
  logic             oe_long;
  logic             drive_d;

  assign cas_fall    = s.cas & ~cas_prev;
  assign cas_rise    = ~s.cas & cas_prev;
  assign page_idle   = ~s.cas & s.ras;
  assign oe_pulse_on = page_idle & ~s.oe;
  assign oe_long     = oe_pulse_on & (oe_cnt == CNT_LAST);

  assign load    = rd_valid & s.ras & s.cas & ~s.we & ~early_wr & ~cas_fall;
  assign drive_d = s.ras & data_ok & ~early_wr & ~off_sticky & s.oe & ~s.we;

  // Width counter for the output-enable pulse during column precharge
  always_ff @(posedge clk) begin
    if (rst || !oe_pulse_on)  oe_cnt <= '0;
    else if (oe_cnt != CNT_LAST) oe_cnt <= oe_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_prev   <= 1'b0;
      early_wr   <= 1'b0;
      data_ok    <= 1'b0;
      off_sticky <= 1'b0;
      dq_oe      <= 1'b0;
    end else begin
      cas_prev <= s.cas;
      dq_oe    <= drive_d;
      if (cas_fall) begin
        early_wr   <= s.we;
        data_ok    <= 1'b0;
        off_sticky <= 1'b0;
      end else begin
        if (!s.ras)    data_ok <= 1'b0;
        else if (load) data_ok <= 1'b1;
        if (cas_rise && !s.oe)                   off_sticky <= 1'b1;
        else if (page_idle && (s.we || oe_long)) off_sticky <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edo_data_hold.sv
module edo_data_hold #(
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DQ_W-1:0] din,
  output logic [DQ_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/edo_dq_drive.sv
module edo_dq_drive
  import edo_dq_pkg::*;
#(
  parameter int DQ_W       = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int OEP_MIN    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            rd_valid,
  input  logic [DQ_W-1:0] rd_data,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_out
);
  logic [STROBE_N-1:0] pins_n;
  logic [STROBE_N-1:0] pins_sync_n;
  strobe_t             strb;
  logic                load;
  logic                cas_fall;
  logic                early_wr;
  logic                off_sticky;

  assign pins_n = {ras_n, cas_n, we_n, oe_n};

  edo_strobe_sync #(
    .WIDTH  (STROBE_N),
    .STAGES (SYNC_DEPTH),
    .RST_VAL({STROBE_N{1'b1}})
  ) u_sync (
    .clk(clk), .rst(rst), .d(pins_n), .q(pins_sync_n)
  );

  assign strb = strobe_t'(~pins_sync_n);

  edo_drive_ctl #(.OEP_MIN(OEP_MIN)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .s         (strb),
    .rd_valid  (rd_valid),
    .load      (load),
    .dq_oe     (dq_oe),
    .cas_fall  (cas_fall),
    .early_wr  (early_wr),
    .off_sticky(off_sticky)
  );

  edo_data_hold #(.DQ_W(DQ_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .din(rd_data), .dout(dq_out)
  );
endmodule

// File: rtl/edo_dq_drive_chk.sv
module edo_dq_drive_chk #(
  parameter int DQ_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ras_a,
  input logic            cas_a,
  input logic            cas_fall,
  input logic            early_wr,
  input logic            off_sticky,
  input logic            dq_oe,
  input logic [DQ_W-1:0] dq_out
);
  p_reset_hiz_r1: assert property (@(posedge clk)
    rst |=> (!dq_oe && dq_out == '0));

  p_fresh_access_r3: assert property (@(posedge clk) disable iff (rst)
    cas_fall |=> ##1 !dq_oe);

  p_hold_data_r4: assert property (@(posedge clk) disable iff (rst)
    !cas_a |=> $stable(dq_out));

  p_sticky_off_r5: assert property (@(posedge clk) disable iff (rst)
    (off_sticky && !cas_fall) |=> !dq_oe);

  p_early_write_r8: assert property (@(posedge clk) disable iff (rst)
    early_wr |=> !dq_oe);

  p_row_closed_r10: assert property (@(posedge clk) disable iff (rst)
    !ras_a |=> !dq_oe);
endmodule

bind edo_dq_drive edo_dq_drive_chk #(.DQ_W(DQ_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_a     (strb.ras),
  .cas_a     (strb.cas),
  .cas_fall  (cas_fall),
  .early_wr  (early_wr),
  .off_sticky(off_sticky),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out)
);

// File: tb/edo_dq_drive_tb.sv
module edo_dq_drive_tb;
  localparam int DQ_W    = 4;
  localparam int OEP_MIN = 3;
  localparam int SETTLE  = 6;

  typedef struct {
    string           tag;
    logic            oe;
    logic [DQ_W-1:0] data;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic            rd_valid = 1'b0;
  logic [DQ_W-1:0] rd_data = '0;
  logic            dq_oe;
  logic [DQ_W-1:0] dq_out;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #5 clk = ~clk;

  edo_dq_drive #(.DQ_W(DQ_W), .SYNC_DEPTH(2), .OEP_MIN(OEP_MIN)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

  // Monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk);
      begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (dq_oe !== e.oe || dq_out !== e.data) begin
          fails++;
          $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                   e.tag, dq_oe, dq_out, e.oe, e.data);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic oe, input logic [DQ_W-1:0] d);
    exp_t e;
    e.tag = tag; e.oe = oe; e.data = d;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    step(1);
  endtask

  task automatic pulse_data(input logic [DQ_W-1:0] d);
    rd_data = d; rd_valid = 1'b1;
    step(1);
    rd_valid = 1'b0;
    step(SETTLE);
  endtask

  task automatic oe_pulse(input int n);
    oe_n = 1'b1;
    step(n);
    oe_n = 1'b0;
    step(SETTLE);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(2);
    expect_out("R1 reset", 1'b0, 4'h0);

    // Read access
    ras_n = 1'b0; step(3);
    oe_n = 1'b0; cas_n = 1'b0; step(SETTLE);
    expect_out("R3 no data yet", 1'b0, 4'h0);
    pulse_data(4'hA);
    expect_out("R2 read drive", 1'b1, 4'hA);
    oe_n = 1'b1; step(SETTLE);
    expect_out("R7 oe high", 1'b0, 4'hA);
    oe_n = 1'b0; step(SETTLE);
    expect_out("R7 oe low", 1'b1, 4'hA);
    cas_n = 1'b1; step(SETTLE);
    expect_out("R4 edo hold", 1'b1, 4'hA);
    oe_pulse(1);
    expect_out("R6 short pulse", 1'b1, 4'hA);
    oe_pulse(OEP_MIN + 2);
    expect_out("R6 long pulse", 1'b0, 4'hA);

    // Next column: released, new data
    cas_n = 1'b0; step(SETTLE);
    expect_out("R3 new access", 1'b0, 4'hA);
    pulse_data(4'h5);
    expect_out("R6 released", 1'b1, 4'h5);
    oe_n = 1'b1; step(SETTLE);
    cas_n = 1'b1; step(SETTLE);
    oe_n = 1'b0; step(SETTLE);
    expect_out("R5 oe across rise", 1'b0, 4'h5);
    cas_n = 1'b0; step(SETTLE);
    pulse_data(4'h3);
    expect_out("R5 released", 1'b1, 4'h3);
    cas_n = 1'b1; step(SETTLE);
    expect_out("R4 hold again", 1'b1, 4'h3);
    we_n = 1'b0; step(SETTLE);
    expect_out("R9 we low", 1'b0, 4'h3);
    we_n = 1'b1; step(SETTLE);
    expect_out("R9 sticky", 1'b0, 4'h3);
    cas_n = 1'b0; step(SETTLE);
    pulse_data(4'hC);
    expect_out("R2 read C", 1'b1, 4'hC);
    ras_n = 1'b1; step(SETTLE);
    expect_out("R10 row close", 1'b0, 4'hC);
    cas_n = 1'b1; step(SETTLE);

    // Early write
    ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; step(3);
    cas_n = 1'b0; step(SETTLE);
    pulse_data(4'h7);
    expect_out("R8 early write", 1'b0, 4'hC);
    we_n = 1'b1; step(SETTLE);
    expect_out("R8 whole access", 1'b0, 4'hC);
    cas_n = 1'b1; ras_n = 1'b1; step(SETTLE);

    // Row-only cycle
    ras_n = 1'b0; step(SETTLE);
    pulse_data(4'h9);
    expect_out("R11 row only", 1'b0, 4'hC);
    ras_n = 1'b1; step(SETTLE);
    expect_out("R11 after", 1'b0, 4'hC);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule